// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This block is a Moore state machine that counts credit from a single coin slot and lets the release mechanism act once the credit reaches the price of 15 cents. The slot accepts two coin kinds: a nickel worth 5 cents and a dime worth 10 cents. Each coin arrives as a pulse one clock cycle wide on its own sense line. No change is ever returned. Any payment above the price is absorbed into a terminal paid state. The controller leaves that state only through reset.

The credit is held in a two-bit register. The release output decodes that register alone, so coin pulses never reach the output through combinational logic. A clash occurs when both sense lines pulse in the same cycle. The controller does not guess which coin was meant. It keeps its credit and raises an error flag for one cycle. The coin inputs are plain control pulses with no handshake, so there is no back-pressure. The controller samples both sense lines on every edge.

Top module: `vend_credit_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is credit code 00 (0 cents), `release_o` is 0 and `coin_err_o` is 0. Reset is synchronous and active high.
- R2: `credit_o` encodes the credit: 0 cents as 00, 5 cents as 01, 10 cents as 10 and 15 cents as 11.
- R3: A nickel pulse alone (`nickel_i`=1, `dime_i`=0) moves the credit from 0 to 5, from 5 to 10, and from 10 to 15 cents at the next edge.
- R4: A dime pulse alone moves the credit from 0 to 10 and from 5 to 15 cents. From 10 cents a dime also goes to 15 cents, because the credit saturates and the excess is kept.
- R5: When neither sense line is high, the credit stays the same across the edge.
- R6: `release_o` is 1 exactly when `credit_o` is 11. It depends only on the stored state.
- R7: In the 15-cent state, a nickel, a dime or both together leave `credit_o` at 11 and `release_o` at 1. Only reset clears this state.
- R8: When `nickel_i` and `dime_i` are both high at an edge, the credit does not change. `coin_err_o` is 1 for the single cycle after that edge. Otherwise it is 0.
- R9: Asserting `rst` in any state, including the 15-cent state, returns the credit to 00 at the next edge. Coins present in that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| nickel_i | input | 1 | One-cycle pulse: a 5-cent coin was sensed |
| dime_i | input | 1 | One-cycle pulse: a 10-cent coin was sensed |
| credit_o | output | 2 | Stored credit code (00/01/10/11 = 0/5/10/15 cents) |
| release_o | output | 1 | Drives the release mechanism; high in the 15-cent state |
| coin_err_o | output | 1 | One-cycle flag after both sense lines pulsed together |

## Verification
The hardest conditions to reach from the ports are a coin clash and overpayment while the controller is already in the terminal state. Both need a specific run of earlier pulses to reach 15 cents first. The stimulus therefore builds credit along every nickel/dime ordering that reaches or passes the price. It then drives lone and simultaneous coins into the paid state, and finally applies reset while coins are still present. A saturating integer model predicts the credit and the outputs after every edge.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // Coin value unit and price, in cents
  parameter int STEP_CENTS  = 5;
  parameter int PRICE_CENTS = 15;
  parameter int NICKEL_CENTS = 5;
  parameter int DIME_CENTS   = 10;

  localparam int LEVELS   = PRICE_CENTS / STEP_CENTS + 1;
  localparam int CREDIT_W = $clog2(LEVELS);
  localparam logic [CREDIT_W-1:0] EMPTY_CODE = '0;
  localparam logic [CREDIT_W-1:0] PAID_CODE  = CREDIT_W'(LEVELS - 1);

  typedef logic [CREDIT_W-1:0] credit_t;

  typedef enum logic [1:0] {
    COIN_NONE   = 2'd0,
    COIN_NICKEL = 2'd1,
    COIN_DIME   = 2'd2,
    COIN_CLASH  = 2'd3
  } coin_t;
endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
(
  input  logic  nickel_i,
  input  logic  dime_i,
  output coin_t coin_o
);
  always_comb begin
    unique case ({dime_i, nickel_i})
      2'b01:   coin_o = COIN_NICKEL;
      2'b10:   coin_o = COIN_DIME;
      2'b11:   coin_o = COIN_CLASH;
      default: coin_o = COIN_NONE;
    endcase
  end
endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next
  import vend_pkg::*;
(
  input  credit_t cur_i,
  input  coin_t   coin_i,
  output credit_t next_o,
  output logic    clash_o
);
  int add_cents;
  int sum_cents;

  always_comb begin
    case (coin_i)
      COIN_NICKEL: add_cents = NICKEL_CENTS;
      COIN_DIME:   add_cents = DIME_CENTS;
      default:     add_cents = 0;
    endcase
    sum_cents = int'(cur_i) * STEP_CENTS + add_cents;
    if (sum_cents > PRICE_CENTS) sum_cents = PRICE_CENTS;
    clash_o = (coin_i == COIN_CLASH);
    if (cur_i == PAID_CODE || clash_o)
      next_o = cur_i;
    else
      next_o = CREDIT_W'(sum_cents / STEP_CENTS);
  end
endmodule

// File: rtl/vend_credit_reg.sv
module vend_credit_reg
  import vend_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  credit_t next_i,
  input  logic    clash_i,
  input  logic    nickel_i,
  input  logic    dime_i,
  output credit_t credit_o,
  output logic    err_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      credit_o <= EMPTY_CODE;
      err_o    <= 1'b0;
    end else begin
      credit_o <= next_i;
      err_o    <= clash_i;
    end
  end

  // R7
  paid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (credit_o == PAID_CODE) |=> (credit_o == PAID_CODE));
  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!nickel_i && !dime_i) |=> $stable(credit_o));
  // R8
  clash_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && dime_i) |=> ($stable(credit_o) && err_o));
  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (!(nickel_i && dime_i)) |=> !err_o);
  // R3
  no_decrease_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (credit_o >= $past(credit_o)));
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (credit_o == EMPTY_CODE && !err_o));
endmodule

// File: rtl/vend_credit_ctrl.sv
module vend_credit_ctrl
  import vend_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                nickel_i,
  input  logic                dime_i,
  output logic [CREDIT_W-1:0] credit_o,
  output logic                release_o,
  output logic                coin_err_o
);
  coin_t   coin;
  credit_t next_credit;
  logic    clash;

  vend_coin_decode u_decode (
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .coin_o   (coin)
  );

  vend_credit_next u_next (
    .cur_i   (credit_o),
    .coin_i  (coin),
    .next_o  (next_credit),
    .clash_o (clash)
  );

  vend_credit_reg u_reg (
    .clk      (clk),
    .rst      (rst),
    .next_i   (next_credit),
    .clash_i  (clash),
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .credit_o (credit_o),
    .err_o    (coin_err_o)
  );

  // Moore output: decoded from stored credit only
  assign release_o = (credit_o == PAID_CODE);

  // R6
  release_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(release_o) |-> $past(nickel_i ^ dime_i));
endmodule

// File: tb/tb_vend_credit_ctrl.sv
module tb_vend_credit_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel_i = 1'b0;
  logic dime_i = 1'b0;
  logic [1:0] credit_o;
  logic release_o;
  logic coin_err_o;

  int total = 0;
  int bad = 0;
  int model_cents = 0;
  logic model_err = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vend_credit_ctrl dut (
    .clk(clk), .rst(rst), .nickel_i(nickel_i), .dime_i(dime_i),
    .credit_o(credit_o), .release_o(release_o), .coin_err_o(coin_err_o)
  );

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    check(tag, "credit", int'(credit_o), model_cents / 5);
    check("R6", "release", int'(release_o), (model_cents == 15) ? 1 : 0);
    check("R8", "coin_err", int'(coin_err_o), int'(model_err));
  endtask

  // Drive one cycle of coins, update the model, check after the edge
  task automatic step(logic n, logic d, string tag);
    @(negedge clk);
    nickel_i = n;
    dime_i = d;
    @(posedge clk);
    #1;
    nickel_i = 1'b0;
    dime_i = 1'b0;
    if (rst) begin
      model_cents = 0;
      model_err = 1'b0;
    end else if (n && d) begin
      model_err = 1'b1;
    end else begin
      model_err = 1'b0;
      if (model_cents != 15) begin
        if (n) model_cents += 5;
        if (d) model_cents += 10;
        if (model_cents > 15) model_cents = 15;
      end
    end
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step(1'b0, 1'b0, "R1");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1", "credit", int'(credit_o), 0);
    check("R1", "release", int'(release_o), 0);
    check("R1", "coin_err", int'(coin_err_o), 0);
  endtask

  task automatic t_nickels();
    do_reset();
    step(1'b1, 1'b0, "R3");
    check("R2", "code 5c", int'(credit_o), 1);
    step(1'b0, 1'b0, "R5");
    step(1'b1, 1'b0, "R3");
    check("R2", "code 10c", int'(credit_o), 2);
    step(1'b0, 1'b0, "R5");
    step(1'b1, 1'b0, "R3");
    check("R2", "code 15c", int'(credit_o), 3);
  endtask

  task automatic t_dime_orders();
    // 0 -> 10 -> 15 by dime then nickel
    do_reset();
    step(1'b0, 1'b1, "R4");
    step(1'b1, 1'b0, "R3");
    // 0 -> 5 -> 15 by nickel then dime
    do_reset();
    step(1'b1, 1'b0, "R3");
    step(1'b0, 1'b1, "R4");
    // overpay: dime then dime saturates at 15
    do_reset();
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, "R4");
    check("R4", "saturated release", int'(release_o), 1);
    // nickel, nickel, dime overpays too
    do_reset();
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b0, "R3");
    step(1'b0, 1'b1, "R4");
  endtask

  task automatic t_paid_ignores();
    do_reset();
    step(1'b0, 1'b1, "R4");
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b0, "R7");
    step(1'b0, 1'b1, "R7");
    step(1'b1, 1'b1, "R7");
    check("R7", "paid after clash", int'(credit_o), 3);
    step(1'b0, 1'b0, "R7");
    check("R7", "still released", int'(release_o), 1);
  endtask

  task automatic t_clash();
    do_reset();
    step(1'b1, 1'b1, "R8");
    check("R8", "clash at 0", int'(credit_o), 0);
    step(1'b0, 1'b0, "R8");
    check("R8", "err one cycle", int'(coin_err_o), 0);
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b1, "R8");
    step(1'b1, 1'b1, "R8");
    check("R8", "clash hold 5c", int'(credit_o), 1);
    step(1'b0, 1'b1, "R4");
    check("R8", "err cleared by coin", int'(coin_err_o), 0);
  endtask

  task automatic t_reset_paid();
    do_reset();
    step(1'b0, 1'b1, "R4");
    step(1'b0, 1'b1, "R4");
    @(negedge clk);
    rst = 1'b1;
    step(1'b1, 1'b0, "R9");
    check("R9", "credit after reset", int'(credit_o), 0);
    check("R9", "release after reset", int'(release_o), 0);
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, 1'b0, "R3");
  endtask

  initial begin
    fork
      begin
        #4_000_000;
        if (!done) begin
          total++;
          bad++;
          $display("FAIL watchdog expired");
          $display("test done: total=%0d bad=%0d", total, bad);
          $finish;
        end
      end
    join_none
    t_reset_state();
    t_nickels();
    t_dime_orders();
    t_paid_ignores();
    t_clash();
    t_reset_paid();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule